// File: doc/BRIEF.md
# DMA Stream Request Arbiter

This block decides which of eight DMA streams owns the next service slot on one transfer port. Every stream has its own group of eight peripheral request lines. A 3-bit channel field on the stream picks one line from that group, and an enable bit on the stream lets that line through. The streams that are requesting are then compared on a 2-bit software priority. When several streams share the top level, the lowest stream number wins.

The winning stream appears as a registered grant. The grant has a valid flag, a one-hot vector and a binary index. It stays fixed while the granted stream moves its single beat or its whole burst. When the stream reports completion with a one-cycle done pulse, the grant is released. Arbitration then runs again in the cycle after the release, using the requests and configuration present in that cycle.

Top module: `strm_req_arbiter`

## Requirements
- R1: Stream s listens only to line `periph_req[s*8 + c]`, where c is the value of its field `chan_sel[s*3 +: 3]`. The other seven lines in its group have no effect on arbitration.
- R2: A stream whose bit in `strm_en` is low is never granted, even when its selected line is high and its priority is the highest.
- R3: Among the eligible streams, the one with the largest value in `prio[s*2 +: 2]` is granted. The levels are 0 low, 1 medium, 2 high and 3 very high.
- R4: When two or more eligible streams share the largest level, the lowest-numbered one of them is granted.
- R5: While `gnt_valid` is high, `gnt_onehot` has exactly one bit set, and that bit is at position `gnt_idx`.
- R6: While no grant is held, `gnt_valid` is low, `gnt_onehot` is all zero and `gnt_idx` is zero.
- R7: While a grant is held and `xfer_done` is low, the grant does not change, whatever the requests or enables do.
- R8: When `xfer_done` is high in a cycle where a grant is held, `gnt_valid` is low after the next rising edge. A new grant can appear one edge later at the earliest.
- R9: Changing the priority or channel field of the granted stream, or of any other stream, while a grant is held has no effect until the next arbitration.
- R10: During reset and right after it, `gnt_valid` is low and the grant outputs are zero.
- R11: With no grant held, the pick made from the inputs present before a rising edge is shown on the outputs right after that edge. `xfer_done` is ignored while no grant is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| strm_en | input | 8 | Enable bit, one per stream |
| chan_sel | input | 24 | 3-bit channel field per stream; stream s in bits s*3+2..s*3 |
| prio | input | 16 | 2-bit software priority per stream; stream s in bits s*2+1..s*2 |
| periph_req | input | 64 | Peripheral request lines; stream s owns bits s*8+7..s*8 |
| xfer_done | input | 1 | One-cycle pulse from the granted stream: its transfer is complete |
| gnt_valid | output | 1 | A grant is held |
| gnt_onehot | output | 8 | One-hot grant vector |
| gnt_idx | output | 3 | Binary index of the granted stream |

## Verification
The grant is the only state, so every result is due exactly one rising edge after the inputs that cause it. A pick made from idle shows after one edge. A release shows one edge after the done pulse. A hold shows as no change after each edge. The bench changes inputs only at falling edges and reads the outputs one nanosecond after the next rising edge. Its model takes that edge's inputs and advances one step, so each comparison pairs one cycle of stimulus with the edge that registers it. Cases where the hold and the idle wait matter, such as changing the configuration under a grant or sending done with nothing granted, are placed so the affected output is checked in the very next cycle.

// File: rtl/strm_arb_pkg.sv
package strm_arb_pkg;

   localparam int PRIO_W = 2;

   typedef enum logic [PRIO_W-1:0] {
      PRIO_LOW   = 2'd0,
      PRIO_MED   = 2'd1,
      PRIO_HIGH  = 2'd2,
      PRIO_VHIGH = 2'd3
   } prio_lvl_e;

endpackage

// File: rtl/strm_chan_mux.sv
module strm_chan_mux #(
   parameter int NUM_CHAN = 8,
   localparam int SEL_W   = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
   input  logic                en,
   input  logic [SEL_W-1:0]    sel,
   input  logic [NUM_CHAN-1:0] lines,
   output logic                req
);

   logic picked;

   always_comb begin
      picked = 1'b0;
      for (int c = 0; c < NUM_CHAN; c++) begin
         if (sel == SEL_W'(c)) picked = lines[c];
      end
   end

   assign req = en & picked;

endmodule

// File: rtl/strm_prio_pick.sv
module strm_prio_pick
   import strm_arb_pkg::*;
#(
   parameter int NUM_STRM = 8,
   localparam int IDX_W   = (NUM_STRM > 1) ? $clog2(NUM_STRM) : 1
) (
   input  logic [NUM_STRM-1:0]        req,
   input  logic [NUM_STRM*PRIO_W-1:0] prio,
   output logic                       found,
   output logic [IDX_W-1:0]           idx
);

   prio_lvl_e best_lvl;
   prio_lvl_e cur_lvl;

   // Scan in ascending order and replace only on a strictly higher level,
   // so equal levels keep the lowest stream number.
   always_comb begin
      found    = 1'b0;
      idx      = '0;
      best_lvl = PRIO_LOW;
      cur_lvl  = PRIO_LOW;
      for (int s = 0; s < NUM_STRM; s++) begin
         cur_lvl = prio_lvl_e'(prio[s*PRIO_W +: PRIO_W]);
         if (req[s] && (!found || (cur_lvl > best_lvl))) begin
            found    = 1'b1;
            idx      = IDX_W'(s);
            best_lvl = cur_lvl;
         end
      end
   end

endmodule

// File: rtl/strm_grant_hold.sv
module strm_grant_hold #(
   parameter int NUM_STRM = 8,
   localparam int IDX_W   = (NUM_STRM > 1) ? $clog2(NUM_STRM) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pick_found,
   input  logic [IDX_W-1:0]    pick_idx,
   input  logic                done,
   output logic                valid,
   output logic [IDX_W-1:0]    idx,
   output logic [NUM_STRM-1:0] onehot
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         idx   <= '0;
      end else if (valid) begin
         if (done) begin
            valid <= 1'b0;
            idx   <= '0;
         end
      end else begin
         valid <= pick_found;
         idx   <= pick_found ? pick_idx : '0;
      end
   end

   for (genvar g = 0; g < NUM_STRM; g++) begin : g_oh
      assign onehot[g] = valid && (idx == IDX_W'(g));
   end

endmodule

// File: rtl/strm_req_arbiter.sv
module strm_req_arbiter
   import strm_arb_pkg::*;
#(
   parameter int NUM_STRM = 8,
   parameter int NUM_CHAN = 8,
   localparam int SEL_W   = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
   localparam int IDX_W   = (NUM_STRM > 1) ? $clog2(NUM_STRM) : 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_STRM-1:0]           strm_en,
   input  logic [NUM_STRM*SEL_W-1:0]     chan_sel,
   input  logic [NUM_STRM*PRIO_W-1:0]    prio,
   input  logic [NUM_STRM*NUM_CHAN-1:0]  periph_req,
   input  logic                          xfer_done,
   output logic                          gnt_valid,
   output logic [NUM_STRM-1:0]           gnt_onehot,
   output logic [IDX_W-1:0]              gnt_idx
);

   if (NUM_STRM < 2) begin : g_bad_strm
      $error("strm_req_arbiter: NUM_STRM must be at least 2");
   end
   if (NUM_CHAN < 2) begin : g_bad_chan
      $error("strm_req_arbiter: NUM_CHAN must be at least 2");
   end

   logic [NUM_STRM-1:0] strm_req;
   logic                pick_found;
   logic [IDX_W-1:0]    pick_idx;

   for (genvar s = 0; s < NUM_STRM; s++) begin : g_strm
      strm_chan_mux #(.NUM_CHAN(NUM_CHAN)) u_mux (
         .en    (strm_en[s]),
         .sel   (chan_sel[s*SEL_W +: SEL_W]),
         .lines (periph_req[s*NUM_CHAN +: NUM_CHAN]),
         .req   (strm_req[s])
      );
   end

   strm_prio_pick #(.NUM_STRM(NUM_STRM)) u_pick (
      .req   (strm_req),
      .prio  (prio),
      .found (pick_found),
      .idx   (pick_idx)
   );

   strm_grant_hold #(.NUM_STRM(NUM_STRM)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .pick_found (pick_found),
      .pick_idx   (pick_idx),
      .done       (xfer_done),
      .valid      (gnt_valid),
      .idx        (gnt_idx),
      .onehot     (gnt_onehot)
   );

endmodule

// File: rtl/strm_req_arbiter_chk.sv
module strm_req_arbiter_chk #(
   parameter int NUM_STRM = 8,
   localparam int IDX_W   = (NUM_STRM > 1) ? $clog2(NUM_STRM) : 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_STRM-1:0] strm_en,
   input logic                xfer_done,
   input logic                gnt_valid,
   input logic [NUM_STRM-1:0] gnt_onehot,
   input logic [IDX_W-1:0]    gnt_idx
);

   logic [NUM_STRM-1:0] prev_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_en <= '0;
      else        prev_en <= strm_en;
   end

   AST_ONEHOT_WHEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_valid |-> ($countones(gnt_onehot) == 1 && gnt_onehot[gnt_idx])); // R5

   AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !gnt_valid |-> (gnt_onehot == '0 && gnt_idx == '0)); // R6

   AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && !xfer_done) |=> (gnt_valid && $stable(gnt_idx))); // R7

   AST_RELEASE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_valid && xfer_done) |=> !gnt_valid); // R8

   AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gnt_valid) |-> prev_en[gnt_idx]); // R2

endmodule

bind strm_req_arbiter strm_req_arbiter_chk #(.NUM_STRM(NUM_STRM)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .strm_en    (strm_en),
   .xfer_done  (xfer_done),
   .gnt_valid  (gnt_valid),
   .gnt_onehot (gnt_onehot),
   .gnt_idx    (gnt_idx)
);

// File: tb/strm_req_arbiter_tb.sv
module strm_req_arbiter_tb;

   localparam int NS = 8;
   localparam int NC = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0]    strm_en = '0;
   logic [NS*3-1:0]  chan_sel = '0;
   logic [NS*2-1:0]  prio = '0;
   logic [NS*NC-1:0] periph_req = '0;
   logic             xfer_done = 1'b0;
   logic             gnt_valid;
   logic [NS-1:0]    gnt_onehot;
   logic [2:0]       gnt_idx;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit m_valid = 1'b0;
   int m_idx = 0;

   always #4 clk = ~clk;

   strm_req_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .strm_en(strm_en), .chan_sel(chan_sel),
      .prio(prio), .periph_req(periph_req), .xfer_done(xfer_done),
      .gnt_valid(gnt_valid), .gnt_onehot(gnt_onehot), .gnt_idx(gnt_idx)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         failures++;
         $display("FAIL watchdog: run did not end, actual cycles=%0d expected below 150000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // Level by level from very high down, stream by stream from 0 up.
   function automatic int model_pick(input logic [NS-1:0] en, input logic [NS*3-1:0] sel,
                                     input logic [NS*2-1:0] pr, input logic [NS*NC-1:0] rq);
      for (int lvl = 3; lvl >= 0; lvl--)
         for (int s = 0; s < NS; s++)
            if (en[s] && rq[s*NC + int'(sel[s*3 +: 3])] && int'(pr[s*2 +: 2]) == lvl)
               return s;
      return -1;
   endfunction

   task automatic check_out(input string tag);
      logic [NS-1:0] exp_oh;
      logic [2:0]    exp_ix;
      exp_oh = m_valid ? (NS'(1) << m_idx) : '0;
      exp_ix = m_valid ? 3'(m_idx) : 3'd0;
      checks++;
      if (gnt_valid !== m_valid || gnt_onehot !== exp_oh || gnt_idx !== exp_ix) begin
         failures++;
         $display("FAIL %s: actual valid=%0b onehot=%b idx=%0d expected valid=%0b onehot=%b idx=%0d",
                  tag, gnt_valid, gnt_onehot, gnt_idx, m_valid, exp_oh, exp_ix);
      end
   endtask

   task automatic step(input logic [NS-1:0] en, input logic [NS*3-1:0] sel,
                       input logic [NS*2-1:0] pr, input logic [NS*NC-1:0] rq,
                       input logic dn, input string tag);
      int p;
      @(negedge clk);
      strm_en = en; chan_sel = sel; prio = pr; periph_req = rq; xfer_done = dn;
      if (m_valid) begin
         if (dn) m_valid = 1'b0;
      end else begin
         p = model_pick(en, sel, pr, rq);
         m_valid = (p >= 0);
         m_idx   = (p >= 0) ? p : 0;
      end
      @(posedge clk);
      #1;
      check_out(tag);
   endtask

   function automatic logic [NS*3-1:0] set_sel(input logic [NS*3-1:0] v, input int s, input int c);
      logic [NS*3-1:0] r = v;
      r[s*3 +: 3] = 3'(c);
      return r;
   endfunction

   function automatic logic [NS*2-1:0] set_pr(input logic [NS*2-1:0] v, input int s, input int l);
      logic [NS*2-1:0] r = v;
      r[s*2 +: 2] = 2'(l);
      return r;
   endfunction

   initial begin
      logic [NS*3-1:0] sel;
      logic [NS*2-1:0] pr;
      logic [NS*NC-1:0] rq;
      void'($urandom(32'd20240611));

      // R10: outputs quiet during reset
      repeat (3) @(posedge clk);
      #1;
      check_out("R10 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      step('0, '0, '0, '0, 1'b0, "R10 after reset");

      // R1: unselected line ignored, selected line grants
      sel = set_sel('0, 3, 5);
      rq = '0; rq[3*NC + 4] = 1'b1;
      step('1, sel, '0, rq, 1'b0, "R1 unselected line");
      rq = '0; rq[3*NC + 5] = 1'b1;
      step('1, sel, '0, rq, 1'b0, "R1 selected line R11");
      step('1, sel, '0, rq, 1'b0, "R7 hold");
      step('1, sel, '0, rq, 1'b1, "R8 release");
      step('1, sel, '0, '0, 1'b1, "R6 idle done ignored R11");

      // R2: disabled very-high stream loses to an enabled low one
      pr = set_pr('0, 1, 3);
      rq = '0; rq[1*NC] = 1'b1; rq[6*NC] = 1'b1;
      step(8'b0100_0000, '0, pr, rq, 1'b0, "R2 disabled");
      step(8'b0100_0000, '0, pr, rq, 1'b1, "R8 release");

      // R3 then R9: config changes under a held grant
      pr = set_pr(set_pr(set_pr('0, 2, 1), 5, 3), 7, 2);
      rq = '0; rq[2*NC] = 1'b1; rq[5*NC] = 1'b1; rq[7*NC] = 1'b1;
      step('1, '0, pr, rq, 1'b0, "R3 highest level");
      pr = set_pr(set_pr(pr, 5, 0), 0, 3);
      rq[0] = 1'b1;
      step('1, set_sel('0, 5, 2), pr, rq, 1'b0, "R9 change under grant");
      step('1, '0, pr, rq, 1'b1, "R8 release");
      step('1, '0, pr, rq, 1'b0, "R8 next arbitration R3");
      step('1, '0, pr, rq, 1'b1, "R8 release");

      // R4: equal levels, lowest index wins
      pr = set_pr(set_pr('0, 4, 2), 2, 2);
      rq = '0; rq[4*NC] = 1'b1; rq[2*NC] = 1'b1; rq[6*NC] = 1'b1;
      step('1, '0, pr, rq, 1'b0, "R4 tie");
      step('1, '0, pr, rq, 1'b1, "R8 release");

      // Random traffic
      for (int n = 0; n < 4000; n++) begin
         logic [NS-1:0] en_r;
         logic dn_r;
         string tag;
         en_r = NS'($urandom) | NS'($urandom);
         sel  = {$urandom, $urandom};
         pr   = 16'($urandom);
         rq   = {$urandom & $urandom, $urandom & $urandom};
         dn_r = ($urandom % 4) == 0;
         if (m_valid) tag = dn_r ? "R8 random release" : "R7 R9 random hold";
         else if (model_pick(en_r, sel, pr, rq) >= 0) tag = "R3 R4 R5 random pick";
         else tag = "R6 random idle";
         step(en_r, sel, pr, rq, dn_r, tag);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule